// File: doc/BRIEF.md
# Balloon-Style Retention Register Bank

This block is a word-wide bank of state-keeping registers for a domain whose supply can be switched off. Each bit has a working flip-flop on the switchable supply and a shadow latch on a supply that stays on. Normal traffic uses only the working flip-flops: a write enable loads the data word at a clock edge, and the value is seen on the output. The shadow copy is not in that path. It changes only on an explicit save, and it is read back only on an explicit restore. The domain's supply is modelled as one logical power-good flag. When that flag drops, the working flip-flops are treated as lost and show a fixed scramble pattern. The shadow latches keep their value.

A parameter selects a second style, called live-slave. In this style there is no shadow copy. A single retain input freezes the working register instead, and the frozen value survives a power-down with no save or restore. A small control state machine chooses the per-edge operation of every bit. Its states are ST_RUN (powered, functional), ST_DOWN (supply lost) and ST_FROZEN (retain held, live-slave only). Its transitions are power_loss (ST_RUN to ST_DOWN), power_return (ST_DOWN to ST_RUN), freeze (ST_RUN or ST_DOWN to ST_FROZEN), thaw (ST_FROZEN to ST_RUN while powered) and release_dark (ST_FROZEN to ST_DOWN when retain falls with power still off). Freeze and thaw take priority over the power transitions.

Top module: `rrb_bank`

## Requirements
- R1: An active-low asynchronous reset forces q to 0 and proto_err to 0. It does not touch the shadow copy, so a restore after reset returns the value saved before reset.
- R2: While powered and in the functional state, an edge with wr_en high loads d_in into q. An edge with wr_en low holds q.
- R3: In balloon style, an edge with pgood high, save high and restore low copies the q value from before that edge into the shadow copy. q itself follows R2 at that edge.
- R4: In balloon style, an edge with pgood high, restore high and save low loads the shadow copy into q. Restore wins over wr_en.
- R5: The first edge with pgood low (retain low or ignored) sets q to the scramble pattern, in which bit i is 1 exactly when i mod 3 is 0 (0x49 for 8 bits). Later edges with pgood low leave q unchanged whatever wr_en and d_in are.
- R6: Save and restore are ignored while pgood is low. The shadow copy and q are unaffected.
- R7: In balloon style, an edge with pgood, save and restore all high changes neither q nor the shadow copy, even with wr_en high. It sets proto_err high after that edge. proto_err returns low after the next edge without this combination.
- R8: After power returns, q keeps the scramble pattern until a restore or a write.
- R9: In live-slave style, an edge with retain high leaves q unchanged, whatever pgood, wr_en and d_in are. A value frozen before power-down is still on q after power returns and retain falls.
- R10: In live-slave style, save and restore have no effect and proto_err stays 0. Power loss with retain low scrambles q as in R5.
- R11: In balloon style, the retain input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of working registers and control |
| pgood | input | 1 | Domain supply is up when high |
| wr_en | input | 1 | Load d_in at the clock edge |
| d_in | input | W | Functional data word |
| save | input | 1 | Copy working value into shadow (balloon style) |
| restore | input | 1 | Copy shadow into working register (balloon style) |
| retain | input | 1 | Freeze working register (live-slave style) |
| q | output | W | Working register value |
| proto_err | output | 1 | Save and restore were both requested at the last edge |

## Verification
The assertions assume that reset is only applied and released between clock edges, and that every control input is a clean level sampled at the edge. They make no assumption about the order in which save, restore, pgood and retain arrive. The bench changes its inputs one time unit after each rising edge and applies reset away from any edge. It does drive illegal combinations on purpose, such as save together with restore, or saves while powered off. The properties are written so that those combinations still have defined outcomes.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOWN   = 2'd1,
        ST_FROZEN = 2'd2
    } dom_state_e;

    typedef enum logic [1:0] {
        OP_KEEP     = 2'd0,
        OP_LOAD     = 2'd1,
        OP_RESTORE  = 2'd2,
        OP_SCRAMBLE = 2'd3
    } cell_op_e;

endpackage

// File: rtl/rrb_ctrl.sv
module rrb_ctrl
    import rrb_pkg::*;
#(
    parameter bit LIVE_SLAVE = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pgood,
    input  logic     wr_en,
    input  logic     save,
    input  logic     restore,
    input  logic     retain,
    output cell_op_e op,
    output logic     shadow_we,
    output logic     proto_err
);

    localparam bit HAS_SHADOW = !LIVE_SLAVE;

    dom_state_e st_q;
    dom_state_e st_d;
    logic       frz_req;
    logic       err_d;

    assign frz_req = LIVE_SLAVE && retain;

    // next state: freeze/thaw dominate, then power transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (frz_req)     st_d = ST_FROZEN;   // freeze
                else if (!pgood) st_d = ST_DOWN;     // power_loss
            end
            ST_DOWN: begin
                if (frz_req)     st_d = ST_FROZEN;   // freeze
                else if (pgood)  st_d = ST_RUN;      // power_return
            end
            ST_FROZEN: begin
                if (!frz_req)    st_d = pgood ? ST_RUN : ST_DOWN; // thaw / release_dark
            end
            default:             st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // per-edge operation decoded from where the domain is heading
    always_comb begin
        op        = OP_KEEP;
        shadow_we = 1'b0;
        err_d     = 1'b0;
        unique case (st_d)
            ST_DOWN: begin
                if (st_q != ST_DOWN) op = OP_SCRAMBLE;
            end
            ST_FROZEN: begin
                op = OP_KEEP;
            end
            ST_RUN: begin
                if (HAS_SHADOW && save && restore) begin
                    err_d = 1'b1;
                end else begin
                    shadow_we = HAS_SHADOW && save;
                    if (HAS_SHADOW && restore) op = OP_RESTORE;
                    else if (wr_en)            op = OP_LOAD;
                end
            end
            default: op = OP_KEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= err_d;
    end

    // R7: an error flag is always caused by a simultaneous save/restore while powered
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(save && restore && pgood));

    // R5: once dark and not frozen, nothing moves
    p_dark_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DOWN && !pgood && !frz_req) |-> (op == OP_KEEP && !shadow_we));

    // R6: shadow never written while power is off
    p_no_save_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood |-> !shadow_we);

    generate
        if (LIVE_SLAVE) begin : g_live_chk
            // R10: live-slave style never reports a protocol error
            p_live_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !proto_err);
        end
    endgenerate

endmodule

// File: rtl/rrb_cell.sv
module rrb_cell
    import rrb_pkg::*;
#(
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     shadow_we,
    input  logic     d,
    input  logic     scr,
    output logic     q,
    output logic     sh
);

    // working flip-flop on the switchable supply, input mux selects source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_KEEP:     q <= q;
                OP_LOAD:     q <= d;
                OP_RESTORE:  q <= sh;
                OP_SCRAMBLE: q <= scr;
                default:     q <= q;
            endcase
        end
    end

    generate
        if (HAS_SHADOW) begin : g_shadow
            logic sh_r;
            // always-on shadow: no reset, written only on save
            always_ff @(posedge clk) begin
                if (shadow_we) sh_r <= q;
            end
            assign sh = sh_r;
        end else begin : g_no_shadow
            assign sh = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rrb_bank.sv
module rrb_bank
    import rrb_pkg::*;
#(
    parameter int W          = 8,
    parameter bit LIVE_SLAVE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pgood,
    input  logic         wr_en,
    input  logic [W-1:0] d_in,
    input  logic         save,
    input  logic         restore,
    input  logic         retain,
    output logic [W-1:0] q,
    output logic         proto_err
);

    function automatic logic [W-1:0] scr_pattern();
        logic [W-1:0] p;
        p = '0;
        for (int i = 0; i < W; i++) p[i] = ((i % 3) == 0);
        return p;
    endfunction

    localparam logic [W-1:0] SCR = scr_pattern();

    cell_op_e     op;
    logic         shadow_we;
    logic [W-1:0] shadow_v;

    rrb_ctrl #(.LIVE_SLAVE(LIVE_SLAVE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgood     (pgood),
        .wr_en     (wr_en),
        .save      (save),
        .restore   (restore),
        .retain    (retain),
        .op        (op),
        .shadow_we (shadow_we),
        .proto_err (proto_err)
    );

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            rrb_cell #(.HAS_SHADOW(!LIVE_SLAVE)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .op        (op),
                .shadow_we (shadow_we),
                .d         (d_in[b]),
                .scr       (SCR[b]),
                .q         (q[b]),
                .sh        (shadow_v[b])
            );
        end
    endgenerate

    generate
        if (!LIVE_SLAVE) begin : g_balloon_chk
            // R3: save captures the pre-edge working value
            p_save_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (pgood && save && !restore) |=> (shadow_v == $past(q)));
            // R4: restore returns the shadow value
            p_restore_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (pgood && restore && !save) |=> (q == $past(shadow_v)));
            // R7: conflicting request changes no state
            p_conflict_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (pgood && save && restore) |=> ($stable(q) && $stable(shadow_v) && proto_err));
            // R6: shadow holds while the domain is dark
            p_shadow_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !pgood |=> $stable(shadow_v));
        end else begin : g_live_chk
            // R9: retain freezes the working register
            p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                retain |=> $stable(q));
        end
    endgenerate

endmodule

// File: tb/sim_rrb_bank.sv
`timescale 1ns/1ps
module sim_rrb_bank;

    localparam int W = 8;
    localparam logic [W-1:0] SCR = 8'h49;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pgood = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] d_in = '0;
    logic         save = 1'b0;
    logic         restore = 1'b0;
    logic         retain = 1'b0;
    logic [W-1:0] q_b, q_l;
    logic         err_b, err_l;

    always #2.5 clk = ~clk;

    rrb_bank #(.W(W), .LIVE_SLAVE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .pgood(pgood), .wr_en(wr_en), .d_in(d_in),
        .save(save), .restore(restore), .retain(retain), .q(q_b), .proto_err(err_b));

    rrb_bank #(.W(W), .LIVE_SLAVE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .pgood(pgood), .wr_en(wr_en), .d_in(d_in),
        .save(save), .restore(restore), .retain(retain), .q(q_l), .proto_err(err_l));

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [W-1:0] b_q, b_sh, l_q;
    logic         b_err, b_down;
    int           l_mode; // 0 run, 1 dark, 2 frozen

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        b_q = '0; b_err = 1'b0; b_down = 1'b0;
        l_q = '0; l_mode = 0;
    endtask

    task automatic model_edge();
        logic [W-1:0] old;
        if (!pgood) begin
            if (!b_down) b_q = SCR;
            b_down = 1'b1;
            b_err  = 1'b0;
        end else begin
            b_down = 1'b0;
            if (save && restore) begin
                b_err = 1'b1;
            end else begin
                b_err = 1'b0;
                old = b_q;
                if (save) b_sh = old;
                if (restore) b_q = b_sh;
                else if (wr_en) b_q = d_in;
            end
        end
        if (retain) begin
            l_mode = 2;
        end else if (!pgood) begin
            if (l_mode != 1) l_q = SCR;
            l_mode = 1;
        end else begin
            l_mode = 0;
            if (wr_en) l_q = d_in;
        end
    endtask

    task automatic compare_all();
        chk({cur_req, " balloon q"}, q_b, b_q);
        chk({cur_req, " balloon err"}, {7'd0, err_b}, {7'd0, b_err});
        chk({cur_req, " live q"}, q_l, l_q);
        chk({cur_req, " live err"}, {7'd0, err_l}, 8'd0);
    endtask

    task automatic step(input logic w, input logic [W-1:0] dv, input logic sv,
                        input logic rv, input logic pg, input logic rt);
        wr_en = w; d_in = dv; save = sv; restore = rv; pgood = pg; retain = rt;
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        #1;
        model_reset();
        chk("R1 reset q", q_b, 8'h00);
        chk("R1 reset q live", q_l, 8'h00);
        chk("R1 reset err", {7'd0, err_b}, 8'd0);
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        b_sh = '0;
        #1;
        apply_reset();

        cur_req = "R2";
        step(1, 8'h3C, 0, 0, 1, 0);
        step(0, 8'hFF, 0, 0, 1, 0);
        step(0, 8'h12, 0, 0, 1, 0);
        chk("R2 hold", q_b, 8'h3C);

        cur_req = "R3";
        step(1, 8'h77, 1, 0, 1, 0);   // shadow <- 3C, q <- 77
        chk("R3 q follows write", q_b, 8'h77);
        step(1, 8'hAA, 0, 0, 1, 0);

        cur_req = "R4";
        step(1, 8'h11, 0, 1, 1, 0);
        chk("R4 restore wins", q_b, 8'h3C);

        cur_req = "R7";
        step(1, 8'h99, 1, 1, 1, 0);
        chk("R7 err set", {7'd0, err_b}, 8'd1);
        chk("R7 q unchanged", q_b, 8'h3C);
        step(0, 8'h00, 0, 1, 1, 0);   // restore: shadow still 3C
        chk("R7 err cleared", {7'd0, err_b}, 8'd0);
        chk("R7 shadow untouched", q_b, 8'h3C);

        cur_req = "R5";
        step(1, 8'hC3, 0, 0, 1, 0);
        step(0, 8'h00, 1, 0, 1, 0);   // shadow <- C3
        step(1, 8'h5F, 0, 0, 0, 0);
        chk("R5 scramble balloon", q_b, SCR);
        chk("R5 scramble live", q_l, SCR);
        step(1, 8'hE1, 0, 0, 0, 0);
        chk("R5 dark hold", q_b, SCR);

        cur_req = "R6";
        step(1, 8'h0F, 1, 0, 0, 0);
        step(0, 8'h0F, 0, 1, 0, 0);
        chk("R6 dark restore ignored", q_b, SCR);

        cur_req = "R8";
        step(0, 8'h00, 0, 0, 1, 0);
        chk("R8 scramble kept", q_b, SCR);
        cur_req = "R10";
        step(0, 8'h00, 0, 1, 1, 0);
        chk("R6 shadow kept across dark", q_b, 8'hC3);
        chk("R10 live restore no effect", q_l, SCR);

        cur_req = "R1";
        apply_reset();
        step(0, 8'h00, 0, 1, 1, 0);
        chk("R1 shadow survives reset", q_b, 8'hC3);

        cur_req = "R9";
        step(1, 8'h5A, 0, 0, 1, 0);
        step(1, 8'h66, 0, 0, 1, 1);
        chk("R9 frozen", q_l, 8'h5A);
        chk("R11 retain ignored", q_b, 8'h66);
        step(1, 8'h21, 0, 0, 0, 1);
        step(1, 8'h22, 1, 1, 0, 1);
        chk("R9 frozen dark", q_l, 8'h5A);
        step(0, 8'h00, 0, 0, 1, 1);
        step(0, 8'h00, 0, 0, 1, 0);
        chk("R9 value after wake", q_l, 8'h5A);
        step(1, 8'h34, 0, 0, 1, 0);
        chk("R9 normal after thaw", q_l, 8'h34);

        cur_req = "R11";
        step(1, 8'hB7, 0, 0, 1, 1);
        chk("R11 balloon write with retain", q_b, 8'hB7);

        cur_req = "mixed R2";
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], lf[15:8], lf[1] & lf[2], lf[3] & lf[4],
                     (lf[5] | lf[6]), lf[7] & lf[9]);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule